// File: doc/BRIEF.md
# Three-Channel Compare and Wrap Timer

This peripheral holds three independent counter channels behind a simple synchronous register bus. Each channel has a live counter, a reload value and two compare values. A channel counts up or down, either on every bus clock or on the rising edges of an external tick. When it runs past its end value, the counter is refilled from the reload value and a wrap event is raised. When the counter steps onto either compare value, a compare event is raised.

All nine events, three per channel, land in one shared sticky status word. One shared mask word selects which of them may interrupt. Each channel drives its own interrupt line, which its interrupt-enable bit in the shared control word also gates. Software typically uses one channel as a free-running time base with interrupts off. It makes a second channel periodic by loading the all-ones value minus (P − 1), or arms a one-shot by writing the current count plus a delta into the first compare register.

Top module: `trio_match_timer`

## Requirements
- R1: After reset every register reads zero and all three interrupt lines are low.
- R2: The register map is as follows. Channel n (n = 0, 1, 2) sits at byte offset 0x10·n, with its counter at +0x0, reload at +0x4, compare A at +0x8 and compare B at +0xC, all read back as written. The control word is at 0x30 and keeps only bits 11:0. Status is at 0x34 and mask at 0x38, both 9 bits wide. Any other word offset, 0x3C or above, reads zero and ignores writes.
- R3: Control bit 3n enables channel n. When bit 3n+1 is 0, an enabled channel advances once per bus clock. A disabled channel holds its count. A bus write to a counter replaces it and takes the place of that cycle's step.
- R4: Control bit 9+n set to 1 selects counting up. An up-counting channel at 0xFFFFFFFF loads its reload value on the next step and sets status bit 3n+2. A reload value of 0xFFFFFFFF − (P − 1) therefore wraps every P steps.
- R5: Control bit 9+n set to 0 selects counting down. A down-counting channel at 0 loads its reload value on the next step and sets status bit 3n+2.
- R6: A step that lands the counter on compare A sets status bit 3n. A step that lands it on compare B sets status bit 3n+1.
- R7: When control bit 3n+1 is 1, an enabled channel advances exactly once for each rising edge of `ext_tick`, after a synchronizer, however long the tick stays high.
- R8: Status bits stay set until software writes a 1 to them. Writing 0 to a status bit leaves it unchanged.
- R9: `irq[n]` is high exactly when control bit 3n+2 is set and at least one of status bits 3n..3n+2 has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW (8) | Byte address; bits 1:0 ignored |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, same cycle |
| ext_tick | input | 1 | Asynchronous external count tick |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
The step assertions assume that a channel's own reload register is not rewritten in the same cycle as a wrap. The stimulus writes reload values only while the channel is stopped or far from its end value. The external-tick checks assume that `ext_tick` stays high and then low for more cycles than the synchronizer depth. The stimulus holds each level for four clocks. Bus writes are driven on the falling clock edge, so every write lands on a known rising edge, and the expected counts are derived from that edge.

// File: rtl/trio_tmr_pkg.sv
package trio_tmr_pkg;

    localparam int NCH      = 3;
    localparam int SRC_PER  = 3;
    localparam int NSRC     = NCH * SRC_PER;
    localparam int CTRL_W   = 12;
    localparam int DIR_BASE = 9;

    typedef enum logic [1:0] {
        REG_CNT  = 2'd0,
        REG_LOAD = 2'd1,
        REG_CMPA = 2'd2,
        REG_CMPB = 2'd3
    } ch_reg_e;

    localparam int WORD_CTRL = 12;
    localparam int WORD_STAT = 13;
    localparam int WORD_MASK = 14;

endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], tick_i};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.last;

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import trio_tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          ext_sel_i,
    input  logic          up_i,
    input  logic          tick_rise_i,
    input  logic          wr_i,
    input  ch_reg_e       wr_sel_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] load_o,
    output logic [DW-1:0] cmpa_o,
    output logic [DW-1:0] cmpb_o,
    output logic          evt_cmpa_o,
    output logic          evt_cmpb_o,
    output logic          evt_wrap_o
);
    localparam logic [DW-1:0] CNT_TOP = '1;
    localparam logic [DW-1:0] CNT_BOT = '0;
    localparam logic [DW-1:0] ONE     = DW'(1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] load;
        logic [DW-1:0] cmpa;
        logic [DW-1:0] cmpb;
    } chan_st_t;

    chan_st_t      st_d, st_q;
    logic          cnt_wr;
    logic          advance;
    logic          at_end;
    logic [DW-1:0] stepped;

    always_comb begin
        cnt_wr  = wr_i && (wr_sel_i == REG_CNT);
        advance = en_i && (ext_sel_i ? tick_rise_i : 1'b1) && !cnt_wr;
        at_end  = up_i ? (st_q.cnt == CNT_TOP) : (st_q.cnt == CNT_BOT);
        if (at_end)    stepped = st_q.load;
        else if (up_i) stepped = st_q.cnt + ONE;
        else           stepped = st_q.cnt - ONE;

        st_d = st_q;
        if (advance) st_d.cnt = stepped;
        if (wr_i) begin
            case (wr_sel_i)
                REG_CNT:  st_d.cnt  = wdata_i;
                REG_LOAD: st_d.load = wdata_i;
                REG_CMPA: st_d.cmpa = wdata_i;
                REG_CMPB: st_d.cmpb = wdata_i;
                default:  st_d      = st_q;
            endcase
        end

        evt_wrap_o = advance && at_end;
        evt_cmpa_o = advance && (stepped == st_q.cmpa);
        evt_cmpb_o = advance && (stepped == st_q.cmpb);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign load_o = st_q.load;
    assign cmpa_o = st_q.cmpa;
    assign cmpb_o = st_q.cmpb;

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !wr_i) |=> $stable(st_q.cnt));

    assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ext_sel_i && up_i && !wr_i && st_q.cnt != CNT_TOP)
        |=> st_q.cnt == $past(st_q.cnt) + ONE);

    assert_up_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ext_sel_i && up_i && !wr_i && st_q.cnt == CNT_TOP)
        |=> st_q.cnt == $past(st_q.load));

    assert_down_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ext_sel_i && !up_i && !wr_i && st_q.cnt != CNT_BOT)
        |=> st_q.cnt == $past(st_q.cnt) - ONE);

    assert_down_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ext_sel_i && !up_i && !wr_i && st_q.cnt == CNT_BOT)
        |=> st_q.cnt == $past(st_q.load));

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import trio_tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            clr_wr_i,
    input  logic            mask_wr_i,
    input  logic [NSRC-1:0] wdata_i,
    input  logic [NCH-1:0]  ie_i,
    output logic [NSRC-1:0] status_o,
    output logic [NSRC-1:0] mask_o,
    output logic [NCH-1:0]  irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] status;
        logic [NSRC-1:0] mask;
    } irq_st_t;

    irq_st_t         st_d, st_q;
    logic [NSRC-1:0] clr_bits;

    always_comb begin
        clr_bits    = clr_wr_i ? wdata_i : '0;
        st_d        = st_q;
        st_d.status = (st_q.status & ~clr_bits) | evt_i;
        if (mask_wr_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_line
        assign irq_o[n] = ie_i[n] &
            (|(st_q.status[n*SRC_PER +: SRC_PER] & st_q.mask[n*SRC_PER +: SRC_PER]));
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr_i |=> ((st_q.status & $past(st_q.status)) == $past(st_q.status)));

    assert_event_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((st_q.status & $past(evt_i)) == $past(evt_i)));

    assert_quiet_when_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.status & st_q.mask) == '0) |-> (irq_o == '0));

endmodule

// File: rtl/trio_match_timer.sv
module trio_match_timer
    import trio_tmr_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic           ext_tick,
    output logic [NCH-1:0] irq
);
    localparam int WW = AW - 2;
    localparam logic [WW-1:0] W_CTRL = WW'(WORD_CTRL);
    localparam logic [WW-1:0] W_STAT = WW'(WORD_STAT);
    localparam logic [WW-1:0] W_MASK = WW'(WORD_MASK);

    logic [WW-1:0]     w_idx;
    logic              addr_lsb_unused;
    logic [NCH-1:0]    ch_hit;
    ch_reg_e           reg_sel;
    logic              tick_rise;
    logic [CTRL_W-1:0] ctrl_d, ctrl_q;
    logic [NCH-1:0]    ie_vec;
    logic [NSRC-1:0]   evt_vec;
    logic [NSRC-1:0]   status_w, mask_w;
    logic [DW-1:0]     rd_cnt  [NCH];
    logic [DW-1:0]     rd_load [NCH];
    logic [DW-1:0]     rd_cmpa [NCH];
    logic [DW-1:0]     rd_cmpb [NCH];

    assign w_idx           = bus_addr[AW-1:2];
    assign addr_lsb_unused = ^bus_addr[1:0];
    assign reg_sel         = ch_reg_e'(w_idx[1:0]);

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_wr && w_idx == W_CTRL) ctrl_d = bus_wdata[CTRL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    tmr_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (ext_tick),
        .rise_o (tick_rise)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign ch_hit[n] = (w_idx[WW-1:2] == (WW-2)'(n));
        assign ie_vec[n] = ctrl_q[n*SRC_PER + 2];

        tmr_channel #(.DW(DW)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .en_i        (ctrl_q[n*SRC_PER]),
            .ext_sel_i   (ctrl_q[n*SRC_PER + 1]),
            .up_i        (ctrl_q[DIR_BASE + n]),
            .tick_rise_i (tick_rise),
            .wr_i        (bus_wr && ch_hit[n]),
            .wr_sel_i    (reg_sel),
            .wdata_i     (bus_wdata),
            .cnt_o       (rd_cnt[n]),
            .load_o      (rd_load[n]),
            .cmpa_o      (rd_cmpa[n]),
            .cmpb_o      (rd_cmpb[n]),
            .evt_cmpa_o  (evt_vec[n*SRC_PER]),
            .evt_cmpb_o  (evt_vec[n*SRC_PER + 1]),
            .evt_wrap_o  (evt_vec[n*SRC_PER + 2])
        );
    end

    tmr_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_vec),
        .clr_wr_i  (bus_wr && w_idx == W_STAT),
        .mask_wr_i (bus_wr && w_idx == W_MASK),
        .wdata_i   (bus_wdata[NSRC-1:0]),
        .ie_i      (ie_vec),
        .status_o  (status_w),
        .mask_o    (mask_w),
        .irq_o     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (ch_hit[n]) begin
                case (reg_sel)
                    REG_CNT:  bus_rdata = rd_cnt[n];
                    REG_LOAD: bus_rdata = rd_load[n];
                    REG_CMPA: bus_rdata = rd_cmpa[n];
                    REG_CMPB: bus_rdata = rd_cmpb[n];
                    default:  bus_rdata = '0;
                endcase
            end
        end
        if (w_idx == W_CTRL) bus_rdata = DW'(ctrl_q);
        if (w_idx == W_STAT) bus_rdata = DW'(status_w);
        if (w_idx == W_MASK) bus_rdata = DW'(mask_w);
    end

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~ie_vec) == '0);

    assert_ctrl_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(ctrl_q));

endmodule

// File: tb/tb_trio_match_timer.sv
module tb_trio_match_timer;
    localparam int CLK_PERIOD = 20;
    localparam int NROWS = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // row: {is_write, addr, data, expected read}
    localparam logic [72:0] TBL [NROWS] = '{
        {1'b1, 8'h00, 32'hA5A5A5A5, 32'h0}, {1'b1, 8'h04, 32'h11111111, 32'h0},
        {1'b1, 8'h08, 32'h22222222, 32'h0}, {1'b1, 8'h0C, 32'h33333333, 32'h0},
        {1'b1, 8'h10, 32'h5A5A5A5A, 32'h0}, {1'b1, 8'h14, 32'h44444444, 32'h0},
        {1'b1, 8'h18, 32'h55555555, 32'h0}, {1'b1, 8'h1C, 32'h66666666, 32'h0},
        {1'b1, 8'h20, 32'h0F0F0F0F, 32'h0}, {1'b1, 8'h24, 32'h77777777, 32'h0},
        {1'b1, 8'h28, 32'h88888888, 32'h0}, {1'b1, 8'h2C, 32'h99999999, 32'h0},
        {1'b0, 8'h00, 32'h0, 32'hA5A5A5A5}, {1'b0, 8'h08, 32'h0, 32'h22222222},
        {1'b0, 8'h14, 32'h0, 32'h44444444}, {1'b0, 8'h1C, 32'h0, 32'h66666666},
        {1'b0, 8'h20, 32'h0, 32'h0F0F0F0F}, {1'b0, 8'h2C, 32'h0, 32'h99999999},
        {1'b1, 8'h38, 32'hFFFFFFFF, 32'h0}, {1'b0, 8'h38, 32'h0, 32'h000001FF},
        {1'b1, 8'h30, 32'hFFFFF000, 32'h0}, {1'b0, 8'h30, 32'h0, 32'h00000000},
        {1'b1, 8'h3C, 32'h12345678, 32'h0}, {1'b0, 8'h3C, 32'h0, 32'h00000000},
        {1'b0, 8'h40, 32'h0, 32'h00000000}
    };

    trio_match_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_tick  (ext_tick),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %h got %h exp %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic [2:0] exp, input string tag);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq got %b exp %b", tag, irq, exp);
        end
    endtask

    task automatic pulse_tick();
        ext_tick = 1'b1; idle(4);
        ext_tick = 1'b0; idle(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        for (int a = 0; a < 15; a++) begin
            chk_rd(8'(a * 4), 32'h0, "R1");
            idle(1);
        end
        chk_irq(3'b000, "R1");

        // R2: table of register writes and readbacks
        for (int i = 0; i < NROWS; i++) begin
            if (TBL[i][72]) wr(TBL[i][71:64], TBL[i][63:32]);
            else begin
                chk_rd(TBL[i][71:64], TBL[i][31:0], "R2");
                idle(1);
            end
        end

        // R3: bus-clock up count, write wins, disable holds
        wr(8'h00, 32'd10);
        wr(8'h30, 32'h201);
        chk_rd(8'h00, 32'd10, "R3");
        idle(5);
        chk_rd(8'h00, 32'd15, "R3");
        wr(8'h00, 32'd1000);
        chk_rd(8'h00, 32'd1000, "R3");
        idle(2);
        chk_rd(8'h00, 32'd1002, "R3");
        wr(8'h30, 32'h0);
        chk_rd(8'h00, 32'd1003, "R3");
        idle(3);
        chk_rd(8'h00, 32'd1003, "R3");
        idle(1);

        // R5: down count and underflow reload; R9, R8 on channel 1
        wr(8'h14, 32'd100);
        wr(8'h10, 32'd2);
        wr(8'h38, 32'h020);
        wr(8'h30, 32'h028);
        chk_rd(8'h10, 32'd2, "R5");
        idle(1);
        chk_rd(8'h10, 32'd1, "R5");
        idle(1);
        chk_rd(8'h10, 32'd0, "R5");
        chk_rd(8'h34, 32'h0, "R5");
        idle(1);
        chk_rd(8'h10, 32'd100, "R5");
        chk_rd(8'h34, 32'h020, "R5");
        chk_irq(3'b010, "R9");
        wr(8'h34, 32'h0);
        chk_rd(8'h34, 32'h020, "R8");
        wr(8'h38, 32'h0);
        chk_irq(3'b000, "R9");
        wr(8'h38, 32'h020);
        chk_irq(3'b010, "R9");
        wr(8'h30, 32'h008);
        chk_irq(3'b000, "R9");
        wr(8'h34, 32'h020);
        chk_rd(8'h34, 32'h0, "R8");
        wr(8'h30, 32'h0);

        // R4: up wrap and periodic reload on channel 2
        wr(8'h34, 32'h1FF);
        wr(8'h20, 32'hFFFFFFFE);
        wr(8'h24, 32'hFFFFFFFC);
        wr(8'h28, 32'hFFFFFFFD);
        wr(8'h38, 32'h1FF);
        wr(8'h30, 32'h840);
        chk_rd(8'h20, 32'hFFFFFFFE, "R4");
        idle(1);
        chk_rd(8'h20, 32'hFFFFFFFF, "R4");
        idle(1);
        chk_rd(8'h20, 32'hFFFFFFFC, "R4");
        chk_rd(8'h34, 32'h100, "R4");
        chk_irq(3'b000, "R9");
        idle(1);
        chk_rd(8'h34, 32'h140, "R6");
        idle(3);
        chk_rd(8'h20, 32'hFFFFFFFC, "R4");
        wr(8'h30, 32'h0);
        wr(8'h34, 32'h1FF);
        chk_rd(8'h34, 32'h0, "R8");

        // R6: compare A one-shot and compare B on channel 0
        wr(8'h00, 32'd100);
        wr(8'h08, 32'd102);
        wr(8'h0C, 32'd105);
        wr(8'h38, 32'h003);
        wr(8'h30, 32'h205);
        chk_rd(8'h00, 32'd100, "R6");
        chk_rd(8'h34, 32'h0, "R6");
        idle(1);
        chk_rd(8'h34, 32'h0, "R6");
        chk_irq(3'b000, "R6");
        idle(1);
        chk_rd(8'h00, 32'd102, "R6");
        chk_rd(8'h34, 32'h001, "R6");
        chk_irq(3'b001, "R9");
        idle(3);
        chk_rd(8'h00, 32'd105, "R6");
        chk_rd(8'h34, 32'h003, "R6");
        wr(8'h30, 32'h0);
        wr(8'h34, 32'h1FF);

        // R7: external tick counts once per rising edge
        wr(8'h00, 32'd0);
        wr(8'h30, 32'h203);
        chk_rd(8'h00, 32'd0, "R7");
        idle(5);
        chk_rd(8'h00, 32'd0, "R7");
        idle(1);
        pulse_tick();
        chk_rd(8'h00, 32'd1, "R7");
        idle(1);
        pulse_tick();
        pulse_tick();
        chk_rd(8'h00, 32'd3, "R7");
        idle(1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule